// File: doc/BRIEF.md
# Control/Status Register Access Executor

This block carries out the six control/status register access instructions of a 32-bit integer core: swap, set-bits and clear-bits, each with a register source or a 5-bit immediate source. In the cycle an instruction word is presented with `instr_valid`, the block decodes it and drives a single-cycle access port toward the register file that holds the control/status registers. That port has a read strobe, a write strobe, a 12-bit register number and write data. In the same cycle the register file returns the current contents and a per-register mask of writable bits. The read and the write of one instruction happen in that same cycle, so no other access can fall between them.

The register file returns the current value combinationally for whatever number is on `csr_addr`. Read side effects are tied to `csr_re` and write side effects to `csr_we`. The block holds back `csr_re` when a swap targets integer register zero. It holds back `csr_we` when a set or clear names source field zero. When an instruction tries to write a register whose number marks it as read-only, the block raises a fault and issues no access at all. The write-back value for the destination register and the fault flag come out of a registered result stage one cycle later.

The result stage is a two-state machine. `ST_IDLE` means no result is on the outputs. `ST_RESULT` means a result for the previous cycle's instruction is on the outputs. The transition `ST_IDLE -> ST_RESULT` happens on a decoded instruction. `ST_RESULT -> ST_RESULT` happens on a back-to-back decoded instruction. `ST_RESULT -> ST_IDLE` happens when no decoded instruction arrives. `ST_IDLE -> ST_IDLE` happens otherwise. Reset forces `ST_IDLE`.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction is decoded only when `instr[6:0]` is 7'b1110011 and `instr[13:12]` is not 2'b00. funct3 (`instr[14:12]`) 001/010/011 select swap/set/clear with the register source, and 101/110/111 select the same operations with the immediate source. Any other word (funct3 000 or 100, or another opcode) makes no access, no write-back and no fault.
- R2: `csr_addr` equals `instr[31:20]` whenever `csr_re` or `csr_we` is high.
- R3: Swap writes the whole source to the register (subject to R8) and returns the old value to the destination. The source is `rs1_val` for funct3[2]=0, or `instr[19:15]` zero-extended for funct3[2]=1.
- R4: A swap whose destination field `instr[11:7]` is zero keeps `csr_re` low and produces no write-back, but still writes.
- R5: Set writes old OR source. Clear writes old AND NOT source. Both return the old value to the destination.
- R6: A set or clear whose `instr[19:15]` is zero keeps `csr_we` low and still reads. It raises no fault even on a read-only register.
- R7: A set or clear naming a nonzero source register that holds zero still asserts `csr_we`, with the old value as data.
- R8: Bits where `csr_wmask` is 0 keep their old value in `csr_wdata`.
- R9: A register is read-only when `instr[31:30]` is 2'b11. A write attempt to it raises `illegal` one cycle later and suppresses `csr_re`, `csr_we` and the write-back.
- R10: `csr_re`/`csr_we` respond in the cycle of `instr_valid`. `rd_we`, `rd_addr`, `rd_wdata` and `illegal` are valid in the following cycle only. An instruction sees the value written by the instruction just before it.
- R11: After reset `rd_we` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of the source integer register |
| csr_re | output | 1 | Read strobe (read side effects) |
| csr_we | output | 1 | Write strobe (write side effects) |
| csr_addr | output | 12 | Control/status register number |
| csr_wdata | output | XLEN | Merged write data |
| csr_rdata | input | XLEN | Current register contents |
| csr_wmask | input | XLEN | Writable-bit mask of the addressed register |
| rd_we | output | 1 | Destination write-back enable |
| rd_addr | output | 5 | Destination register index |
| rd_wdata | output | XLEN | Old register value for the destination |
| illegal | output | 1 | Write attempt to a read-only register |

## Verification
The access strobes, register number and write data respond in the same cycle, so the bench drives each instruction at a falling edge and samples the port 1 ns later, before the rising edge commits the write. The write-back and fault outputs pass through one register, so the bench samples them at the next falling edge, with `instr_valid` already dropped. A back-to-back pair checks that the second result is due exactly one cycle after its own instruction and that it returns the data the first instruction wrote. A further idle cycle checks that the result does not linger.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;

    localparam logic [6:0] SYS_OPCODE = 7'b1110011;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SWAP  = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } exec_state_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_exec_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 5
) (
    input  logic [INSTR_W-1:0] instr,
    output csr_op_e            op,
    output logic               use_imm,
    output logic [IDX_W-1:0]   rd_idx,
    output logic [IDX_W-1:0]   src_idx,
    output logic [ADDR_W-1:0]  reg_num
);
    localparam int RD_LO  = 7;
    localparam int F3_LO  = RD_LO + IDX_W;
    localparam int SRC_LO = F3_LO + 3;

    logic [2:0] f3;

    assign f3      = instr[F3_LO +: 3];
    assign rd_idx  = instr[RD_LO +: IDX_W];
    assign src_idx = instr[SRC_LO +: IDX_W];
    assign reg_num = instr[INSTR_W-1 -: ADDR_W];
    assign use_imm = f3[2];

    always_comb begin
        op = OP_NONE;
        if (instr[6:0] == SYS_OPCODE) begin
            unique case (f3[1:0])
                2'b01:   op = OP_SWAP;
                2'b10:   op = OP_SET;
                2'b11:   op = OP_CLEAR;
                default: op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/csr_merge.sv
module csr_merge
    import csr_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e          op,
    input  logic [XLEN-1:0]  old_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  wr_mask,
    output logic [XLEN-1:0]  new_val
);
    logic [XLEN-1:0] raw;

    always_comb begin
        unique case (op)
            OP_SWAP:  raw = src_val;
            OP_SET:   raw = old_val | src_val;
            OP_CLEAR: raw = old_val & ~src_val;
            default:  raw = old_val;
        endcase
    end

    // protected bits always come from the old value
    assign new_val = (old_val & ~wr_mask) | (raw & wr_mask);

endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
    import csr_exec_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   rs1_val,
    output logic              csr_re,
    output logic              csr_we,
    output logic [ADDR_W-1:0] csr_addr,
    output logic [XLEN-1:0]   csr_wdata,
    input  logic [XLEN-1:0]   csr_rdata,
    input  logic [XLEN-1:0]   csr_wmask,
    output logic              rd_we,
    output logic [IDX_W-1:0]  rd_addr,
    output logic [XLEN-1:0]   rd_wdata,
    output logic              illegal
);
    localparam int PAD_W = XLEN - IDX_W;

    csr_op_e          op;
    logic             use_imm;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] src_idx;
    logic [XLEN-1:0]  src_val;

    logic acc, is_swap, wants_wr, wants_rd, ro_reg, fault, wb_next;

    exec_state_e state_q, state_d;
    logic              wb_q, fault_q;
    logic [IDX_W-1:0]  rd_q;
    logic [XLEN-1:0]   data_q;

    csr_decode #(
        .INSTR_W (32),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_dec (
        .instr   (instr),
        .op      (op),
        .use_imm (use_imm),
        .rd_idx  (rd_idx),
        .src_idx (src_idx),
        .reg_num (csr_addr)
    );

    assign src_val = use_imm ? {{PAD_W{1'b0}}, src_idx} : rs1_val;

    csr_merge #(
        .XLEN (XLEN)
    ) u_merge (
        .op      (op),
        .old_val (csr_rdata),
        .src_val (src_val),
        .wr_mask (csr_wmask),
        .new_val (csr_wdata)
    );

    // access control
    assign acc      = instr_valid && (op != OP_NONE);
    assign is_swap  = (op == OP_SWAP);
    assign wants_wr = is_swap || (src_idx != '0);
    assign wants_rd = !is_swap || (rd_idx != '0);
    assign ro_reg   = (csr_addr[ADDR_W-1 -: 2] == 2'b11);
    assign fault    = acc && wants_wr && ro_reg;
    assign csr_re   = acc && wants_rd && !fault;
    assign csr_we   = acc && wants_wr && !fault;
    assign wb_next  = acc && !fault && (rd_idx != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = acc ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = acc ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q    <= 1'b0;
            fault_q <= 1'b0;
            rd_q    <= '0;
            data_q  <= '0;
        end else begin
            wb_q    <= wb_next;
            fault_q <= fault;
            if (acc) begin
                rd_q   <= rd_idx;
                data_q <= csr_rdata;
            end
        end
    end

    assign rd_we    = (state_q == ST_RESULT) && wb_q;
    assign illegal  = (state_q == ST_RESULT) && fault_q;
    assign rd_addr  = rd_q;
    assign rd_wdata = data_q;

endmodule

// File: rtl/csr_exec_chk.sv
module csr_exec_chk #(
    parameter int XLEN   = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [31:0]       instr,
    input logic              csr_re,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [XLEN-1:0]   csr_wdata,
    input logic [XLEN-1:0]   csr_rdata,
    input logic [XLEN-1:0]   csr_wmask,
    input logic              rd_we,
    input logic              illegal
);
    // R9
    ro_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |-> (csr_addr[ADDR_W-1 -: 2] != 2'b11));

    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |-> (((csr_wdata ^ csr_rdata) & ~csr_wmask) == '0));

    // R4
    swap_x0_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] == 7'b1110011 && instr[13:12] == 2'b01
         && instr[11:7] == 5'd0) |-> !csr_re);

    // R6
    setclr_zero_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] == 7'b1110011 && instr[13]
         && instr[19:15] == 5'd0) |-> !csr_we);

    // R1
    foreign_noaccess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] != 7'b1110011) |-> (!csr_re && !csr_we));

    // R10
    result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || illegal) |-> $past(instr_valid));

    // R9
    fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rd_we);

endmodule

bind csr_exec_unit csr_exec_chk #(
    .XLEN   (XLEN),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .csr_re      (csr_re),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .csr_wmask   (csr_wmask),
    .rd_we       (rd_we),
    .illegal     (illegal)
);

// File: tb/sim_csr_exec_unit.sv
module sim_csr_exec_unit;
    localparam int XLEN = 32;
    localparam int NREG = 8;
    localparam int NV   = 17;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] rs1v;
        logic        wb;
        logic        re;
        logic        we;
        logic        ill;
    } vec_t;

    function automatic logic [31:0] mk(input logic [11:0] a, input logic [4:0] s,
                                       input logic [2:0] f, input logic [4:0] d,
                                       input logic [6:0] o);
        return {a, s, f, d, o};
    endfunction

    function automatic logic [31:0] init_val(input int i);
        return 32'hA5A5_0000 | (i * 32'h11);
    endfunction

    function automatic logic [31:0] mask_of(input logic [2:0] i);
        return i[0] ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    localparam logic [6:0] SY = 7'b1110011;
    localparam logic [11:0] RA = 12'h300, RB = 12'h341, RC = 12'h302, RO = 12'hC03;

    localparam vec_t VECS [NV] = '{
        '{mk(RA, 5'd7, 3'b001, 5'd5, SY), 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RA, 5'd7, 3'b001, 5'd0, SY), 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0},
        '{mk(RB, 5'd8, 3'b010, 5'd6, SY), 32'hFFFF_00F0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RA, 5'd8, 3'b011, 5'd6, SY), 32'h0000_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RC, 5'd0, 3'b010, 5'd9, SY), 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0},
        '{mk(RC, 5'd3, 3'b010, 5'd9, SY), 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RB, 5'd31, 3'b101, 5'd4, SY), 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RC, 5'd5, 3'b101, 5'd0, SY), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0},
        '{mk(RA, 5'd18, 3'b110, 5'd4, SY), 32'h0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RB, 5'd3, 3'b111, 5'd4, SY), 32'h0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{mk(RO, 5'd0, 3'b110, 5'd4, SY), 32'h0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{mk(RO, 5'd2, 3'b010, 5'd4, SY), 32'h1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{mk(RO, 5'd2, 3'b001, 5'd0, SY), 32'h7, 1'b0, 1'b0, 1'b0, 1'b1},
        '{mk(RO, 5'd0, 3'b111, 5'd0, SY), 32'h0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{mk(RA, 5'd4, 3'b000, 5'd4, SY), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{mk(RA, 5'd4, 3'b100, 5'd4, SY), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0},
        '{mk(RA, 5'd4, 3'b001, 5'd4, 7'b0110011), 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic        csr_re, csr_we, rd_we, illegal;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata, csr_rdata, csr_wmask, rd_wdata;
    logic [4:0]  rd_addr;

    logic [31:0] mem    [NREG];
    logic [31:0] refmem [NREG];
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    csr_exec_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .csr_re(csr_re), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_wmask(csr_wmask),
        .rd_we(rd_we), .rd_addr(rd_addr), .rd_wdata(rd_wdata), .illegal(illegal)
    );

    // register storage model
    assign csr_rdata = mem[csr_addr[2:0]];
    assign csr_wmask = mask_of(csr_addr[2:0]);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
        end else if (csr_we) begin
            mem[csr_addr[2:0]] <= csr_wdata;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_new(input logic [31:0] ins, input logic [31:0] rv,
                                               input logic [31:0] old, input logic [31:0] m);
        logic [31:0] src, raw;
        src = ins[14] ? {27'd0, ins[19:15]} : rv;
        case (ins[13:12])
            2'b01:   raw = src;
            2'b10:   raw = old | src;
            default: raw = old & ~src;
        endcase
        return (old & ~m) | (raw & m);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) refmem[i] = init_val(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset values
        chk("R11 rd_we in reset", {31'd0, rd_we}, 32'd0);
        chk("R11 illegal in reset", {31'd0, illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rd_we after reset", {31'd0, rd_we}, 32'd0);
        chk("R11 illegal after reset", {31'd0, illegal}, 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [2:0]  idx;
            logic [31:0] old, nv;
            v = VECS[i];
            idx = v.instr[22:20];
            old = refmem[idx];
            nv  = expect_new(v.instr, v.rs1v, old, mask_of(idx));
            instr = v.instr;
            rs1_val = v.rs1v;
            instr_valid = 1'b1;
            #1;
            chk($sformatf("R1 R4 R6 R9 csr_re v%0d", i), {31'd0, csr_re}, {31'd0, v.re});
            chk($sformatf("R1 R6 R7 R9 csr_we v%0d", i), {31'd0, csr_we}, {31'd0, v.we});
            if (v.re || v.we)
                chk($sformatf("R2 csr_addr v%0d", i), {20'd0, csr_addr}, {20'd0, v.instr[31:20]});
            if (v.we)
                chk($sformatf("R3 R5 R7 R8 csr_wdata v%0d", i), csr_wdata, nv);
            @(negedge clk);
            instr_valid = 1'b0;
            chk($sformatf("R10 rd_we v%0d", i), {31'd0, rd_we}, {31'd0, v.wb});
            chk($sformatf("R9 illegal v%0d", i), {31'd0, illegal}, {31'd0, v.ill});
            if (v.wb) begin
                chk($sformatf("R3 R5 rd_wdata v%0d", i), rd_wdata, old);
                chk($sformatf("R10 rd_addr v%0d", i), {27'd0, rd_addr}, {27'd0, v.instr[11:7]});
            end
            if (v.we) refmem[idx] = nv;
            chk($sformatf("R8 stored value v%0d", i), mem[idx], refmem[idx]);
        end

        // R10: back-to-back, second sees first's write
        instr = mk(RC, 5'd1, 3'b001, 5'd3, SY);
        rs1_val = 32'h0BAD_F00D;
        instr_valid = 1'b1;
        @(negedge clk);
        chk("R10 first rd_we", {31'd0, rd_we}, 32'd1);
        chk("R10 first rd_wdata", rd_wdata, refmem[2]);
        refmem[2] = 32'h0BAD_F00D;
        instr = mk(RC, 5'd0, 3'b010, 5'd7, SY);
        rs1_val = 32'h0;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R10 second rd_we", {31'd0, rd_we}, 32'd1);
        chk("R10 second rd_addr", {27'd0, rd_addr}, 32'd7);
        chk("R10 second sees prior write", rd_wdata, 32'h0BAD_F00D);
        @(negedge clk);
        chk("R10 result lasts one cycle", {31'd0, rd_we}, 32'd0);
        chk("R10 fault idle", {31'd0, illegal}, 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule